// File: doc/BRIEF.md
# Multi-Mode Data Pointer Unit

This block holds the address pointers that an execution core uses for indirect data-memory access. There are three pointers. Two are plain address pointers (P0 and P1). The third is a frame pointer, made from a base register and an offset register. Each pointer keeps one internal bit more than its visible width. A per-pointer mode bit selects which visible window the core sees and steps: the byte window or the word window. Changing a mode bit never alters the stored bits. This lets one stored value be seen as a byte address or as a word address.

The core writes and reads the pointers and a small control register through a register port. It issues indirect accesses on a separate request port. A read access uses the currently selected pointer and may step that pointer after the access. A write access names its pointer explicitly, may step it before the access, and uses the stepped address. All three pointers share one memory port. The unit therefore keeps an active-source select and drives a single address output. The select updates by itself whenever a pointer register is written and whenever an indirect write is performed.

Top module: `ptr_unit`

## Requirements
- R1: After reset, every pointer register and the control register read as zero, and the address output is zero. This means P0 is selected and all pointers are in byte mode.
- R2: Register index encoding on `regSel`/`regRdSel` is 0 = control, 1 = P0, 2 = P1, 3 = frame base, 4 = frame offset. A write to a 16-bit pointer in byte mode (mode bit 0) loads internal bits 15:0 and keeps bit 16. In word mode (mode bit 1) it loads bits 16:1 and keeps bit 0. The offset register works the same way with 8 data bits: bits 7:0 in byte mode, bits 8:1 in word mode. A read returns the window of the current mode, zero-extended. Writes to indices 5 to 7 have no effect, and reads of those indices return zero.
- R3: Changing a mode bit leaves the stored bits untouched. For example: write 2345h in byte mode, write 2345h in word mode, then return to byte mode. P0 then reads 468Bh.
- R4: A step changes only the current window and wraps inside it. A byte-mode P0 at FFFFh steps to 0000h and keeps internal bit 16. A word-mode view taken afterwards still shows that bit.
- R5: An indirect read (`accEn`=1, `accWrite`=0) uses the selected pointer and ignores `accPtr`. The step encoding on `accStep` is 01 = increment, 10 = decrement, 00 and 11 = no step. During the access cycle the address output shows the value before the step, and the stepped value is stored at the clock edge.
- R6: An indirect write (`accEn`=1, `accWrite`=1) uses the pointer named by `accPtr`: 00 = P0, 01 = P1, 1x = frame. During the access cycle the address output already shows the stepped address, and that value is stored at the edge.
- R7: The frame address is the visible base plus the zero-extended visible offset, modulo 2^16. A frame step changes only the offset, wraps within the offset window, and never changes the base.
- R8: Control register layout: bits 1:0 hold the select (00 = P0, 01 = P1, 1x = frame). Bit 2 is the P0 mode, bit 3 the P1 mode and bit 4 the frame mode. A control read returns these five bits with zero above them.
- R9: Writing P0 or P1 sets the select to that pointer. Writing the base or the offset sets the select to 10. An indirect write sets the select to the pointer it used, with the frame recorded as 10. An indirect read leaves the select unchanged.
- R10: In the same cycle, a register write beats a step on the same pointer. A register write also beats an indirect write's update of the select.
- R11: When no indirect write is active, the address output is the visible address of the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register index for the write |
| regWrData | input | 16 | Register write data |
| regRdSel | input | 3 | Register index for the read |
| regRdData | output | 16 | Read data: visible window of the indexed register |
| accEn | input | 1 | Indirect access request |
| accWrite | input | 1 | 1 = indirect write, 0 = indirect read |
| accPtr | input | 2 | Pointer named by an indirect write |
| accStep | input | 2 | Step request: 01 increment, 10 decrement |
| memAddr | output | 16 | Shared data-memory address |

## Verification
The checker properties assume that the register port and the access port may both be active in one cycle. They assume that all values of `regSel` and `accStep` can occur. They also rely on no conflicting control-register write at the moment a pointer register is written. The stimulus keeps within these assumptions by driving `regSel` only with control or pointer indices in the directed phase. Its random phase covers the whole encoding space, including the unused indices and the idle step code. Against a behavioural model, the bench compares the address output and the selected read-back value on every cycle, which covers every combination of mode, select and step.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  parameter int VIS_W = 16;
  parameter int OFF_VIS_W = 8;
  localparam int PTR_IW = VIS_W + 1;
  localparam int OFF_IW = OFF_VIS_W + 1;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_P0   = 3'd1,
    REG_P1   = 3'd2,
    REG_BASE = 3'd3,
    REG_OFFS = 3'd4
  } regId_e;

  typedef struct packed {
    logic       ctrlWr;
    logic [1:0] dpWr;
    logic       baseWr;
    logic       offsWr;
    logic [1:0] dpStep;
    logic       offsStep;
    logic       stepDown;
    logic       useAccPtr;
    logic [1:0] accTgt;
  } strobe_t;

  function automatic logic [VIS_W-1:0] ptrView(logic [PTR_IW-1:0] v, logic word);
    return word ? v[VIS_W:1] : v[VIS_W-1:0];
  endfunction

  function automatic logic [PTR_IW-1:0] ptrLoad(logic [PTR_IW-1:0] v, logic word,
                                                logic [VIS_W-1:0] d);
    return word ? {d, v[0]} : {v[VIS_W], d};
  endfunction

  function automatic logic [PTR_IW-1:0] ptrStep(logic [PTR_IW-1:0] v, logic word, logic down);
    logic [VIS_W-1:0] w;
    w = ptrView(v, word) + (down ? {VIS_W{1'b1}} : VIS_W'(1));
    return ptrLoad(v, word, w);
  endfunction

  function automatic logic [OFF_VIS_W-1:0] offView(logic [OFF_IW-1:0] v, logic word);
    return word ? v[OFF_VIS_W:1] : v[OFF_VIS_W-1:0];
  endfunction

  function automatic logic [OFF_IW-1:0] offLoad(logic [OFF_IW-1:0] v, logic word,
                                                logic [OFF_VIS_W-1:0] d);
    return word ? {d, v[0]} : {v[OFF_VIS_W], d};
  endfunction

  function automatic logic [OFF_IW-1:0] offStep(logic [OFF_IW-1:0] v, logic word, logic down);
    logic [OFF_VIS_W-1:0] w;
    w = offView(v, word) + (down ? {OFF_VIS_W{1'b1}} : OFF_VIS_W'(1));
    return offLoad(v, word, w);
  endfunction
endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regSel,
  input  logic [4:0] ctrlData,
  input  logic       accEn,
  input  logic       accWrite,
  input  logic [1:0] accPtr,
  input  logic [1:0] accStep,
  output strobe_t    stb,
  output logic [1:0] selQ,
  output logic [2:0] modeQ
);
  logic       doStep;
  logic [1:0] usePtr;
  logic [1:0] selNext;

  assign doStep = accEn && (accStep == 2'b01 || accStep == 2'b10);
  assign usePtr = (accEn && accWrite) ? accPtr : selQ;

  always_comb begin
    stb           = '0;
    stb.ctrlWr    = regWrEn && (regSel == REG_CTRL);
    stb.dpWr[0]   = regWrEn && (regSel == REG_P0);
    stb.dpWr[1]   = regWrEn && (regSel == REG_P1);
    stb.baseWr    = regWrEn && (regSel == REG_BASE);
    stb.offsWr    = regWrEn && (regSel == REG_OFFS);
    stb.dpStep[0] = doStep && (usePtr == 2'b00);
    stb.dpStep[1] = doStep && (usePtr == 2'b01);
    stb.offsStep  = doStep && usePtr[1];
    stb.stepDown  = (accStep == 2'b10);
    stb.useAccPtr = accEn && accWrite;
    stb.accTgt    = accPtr;
  end

  always_comb begin
    selNext = selQ;
    if (stb.ctrlWr)                    selNext = ctrlData[1:0];
    else if (stb.dpWr[0])              selNext = 2'b00;
    else if (stb.dpWr[1])              selNext = 2'b01;
    else if (stb.baseWr || stb.offsWr) selNext = 2'b10;
    else if (stb.useAccPtr)            selNext = accPtr[1] ? 2'b10 : accPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      modeQ <= '0;
    end else begin
      selQ <= selNext;
      if (stb.ctrlWr) modeQ <= ctrlData[4:2];
    end
  end
endmodule

// File: rtl/ptr_datapath.sv
module ptr_datapath
  import ptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [1:0]       selQ,
  input  logic [2:0]       modeQ,
  input  logic [VIS_W-1:0] regWrData,
  input  logic [2:0]       regRdSel,
  output logic [VIS_W-1:0] regRdData,
  output logic [VIS_W-1:0] memAddr,
  output logic             p0Hi,
  output logic [PTR_IW-1:0] baseOut
);
  logic [PTR_IW-1:0] dpQ   [2];
  logic [PTR_IW-1:0] dpNext[2];
  logic [PTR_IW-1:0] baseQ;
  logic [OFF_IW-1:0] offsQ;
  logic [OFF_IW-1:0] offsNext;
  logic [1:0]        tgt;

  for (genvar i = 0; i < 2; i++) begin : g_dp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              dpQ[i] <= '0;
      else if (stb.dpWr[i])   dpQ[i] <= ptrLoad(dpQ[i], modeQ[i], regWrData);
      else if (stb.dpStep[i]) dpQ[i] <= ptrStep(dpQ[i], modeQ[i], stb.stepDown);
    end
    assign dpNext[i] = stb.dpStep[i] ? ptrStep(dpQ[i], modeQ[i], stb.stepDown) : dpQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      offsQ <= '0;
    end else begin
      if (stb.baseWr) baseQ <= ptrLoad(baseQ, modeQ[2], regWrData);
      if (stb.offsWr)
        offsQ <= offLoad(offsQ, modeQ[2], regWrData[OFF_VIS_W-1:0]);
      else if (stb.offsStep)
        offsQ <= offStep(offsQ, modeQ[2], stb.stepDown);
    end
  end

  assign offsNext = stb.offsStep ? offStep(offsQ, modeQ[2], stb.stepDown) : offsQ;
  assign tgt      = stb.useAccPtr ? stb.accTgt : selQ;

  always_comb begin
    if (tgt[1])
      memAddr = ptrView(baseQ, modeQ[2])
              + VIS_W'(offView(stb.useAccPtr ? offsNext : offsQ, modeQ[2]));
    else if (stb.useAccPtr)
      memAddr = ptrView(dpNext[tgt[0]], modeQ[tgt[0]]);
    else
      memAddr = ptrView(dpQ[tgt[0]], modeQ[tgt[0]]);
  end

  always_comb begin
    case (regRdSel)
      REG_CTRL: regRdData = VIS_W'({modeQ, selQ});
      REG_P0:   regRdData = ptrView(dpQ[0], modeQ[0]);
      REG_P1:   regRdData = ptrView(dpQ[1], modeQ[1]);
      REG_BASE: regRdData = ptrView(baseQ, modeQ[2]);
      REG_OFFS: regRdData = VIS_W'(offView(offsQ, modeQ[2]));
      default:  regRdData = '0;
    endcase
  end

  assign p0Hi    = dpQ[0][VIS_W];
  assign baseOut = baseQ;
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regSel,
  input  logic [15:0] regWrData,
  input  logic [2:0]  regRdSel,
  output logic [15:0] regRdData,
  input  logic        accEn,
  input  logic        accWrite,
  input  logic [1:0]  accPtr,
  input  logic [1:0]  accStep,
  output logic [15:0] memAddr
);
  strobe_t           stb;
  logic [1:0]        selQ;
  logic [2:0]        modeQ;
  logic              p0Hi;
  logic [PTR_IW-1:0] baseQ;

  ptr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .ctrlData(regWrData[4:0]), .accEn(accEn), .accWrite(accWrite),
    .accPtr(accPtr), .accStep(accStep), .stb(stb), .selQ(selQ), .modeQ(modeQ)
  );

  ptr_datapath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .selQ(selQ), .modeQ(modeQ),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .memAddr(memAddr), .p0Hi(p0Hi), .baseOut(baseQ)
  );
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regSel,
  input logic        accEn,
  input logic        accWrite,
  input logic [1:0]  accPtr,
  input logic [1:0]  selQ,
  input logic [2:0]  modeQ,
  input logic        p0Hi,
  input logic [16:0] baseQ
);
  // R7
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regSel == 3'd3) |=> $stable(baseQ));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regSel == 3'd0) |=> $stable(modeQ));

  // R9
  acc_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accWrite && !regWrEn) |=>
      selQ == ($past(accPtr[1]) ? 2'b10 : $past(accPtr)));

  // R9
  read_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWrite && !regWrEn) |=> $stable(selQ));

  // R9
  wr_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 3'd2) |=> selQ == 2'b01);

  // R4
  byte_nocarry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && regSel == 3'd1) && !modeQ[0]) |=> $stable(p0Hi));
endmodule

bind ptr_unit ptr_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .accEn(accEn), .accWrite(accWrite), .accPtr(accPtr),
  .selQ(selQ), .modeQ(modeQ), .p0Hi(p0Hi), .baseQ(baseQ)
);

// File: tb/ptr_unit_tb.sv
module ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [15:0] regWrData = '0;
  logic [2:0]  regRdSel = '0;
  logic [15:0] regRdData;
  logic        accEn = 1'b0;
  logic        accWrite = 1'b0;
  logic [1:0]  accPtr = '0;
  logic [1:0]  accStep = '0;
  logic [15:0] memAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state: four pointers as plain integers, select, modes
  int mPtr[4];  // 0:P0 1:P1 2:base 3:offset(9 bits)
  int mSel;
  int mMode[3];

  ptr_unit dut_i (.*);

  always #5 clk = ~clk;

  function automatic int hiBit(int idx);
    return (idx == 3) ? 256 : 65536;
  endfunction

  function automatic int seen(int idx, int m);
    int span = hiBit(idx);
    return (m != 0) ? (mPtr[idx] / 2) : (mPtr[idx] % span);
  endfunction

  function automatic int placed(int oldV, int idx, int m, int d);
    int span = hiBit(idx);
    d = d % span;
    return (m != 0) ? (d * 2 + (oldV % 2)) : (d + (oldV / span) * span);
  endfunction

  function automatic int modeOf(int idx);
    return (idx >= 2) ? mMode[2] : mMode[idx];
  endfunction

  function automatic int stepped(int idx, int delta);
    int span = hiBit(idx);
    int v = seen(idx, modeOf(idx));
    v = (v + delta + span) % span;
    return placed(mPtr[idx], idx, modeOf(idx), v);
  endfunction

  function automatic int frameAddr(int offVal);
    int o;
    o = (mMode[2] != 0) ? offVal / 2 : offVal % 256;
    return (seen(2, mMode[2]) + o) % 65536;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input int ws, input int wd, input int rs,
                     input bit ae, input bit aw, input int ap, input int st,
                     input string req);
    int delta, used, expAddr, expRd, keep;
    regWrEn = we; regSel = 3'(ws); regWrData = 16'(wd); regRdSel = 3'(rs);
    accEn = ae; accWrite = aw; accPtr = 2'(ap); accStep = 2'(st);
    delta = !ae ? 0 : (st == 1) ? 1 : (st == 2) ? -1 : 0;
    used  = (ae && aw) ? ap : mSel;
    if (used >= 2) used = 3;
    // expected address
    if (ae && aw) begin
      if (used == 3) expAddr = frameAddr(stepped(3, delta));
      else begin
        keep = mPtr[used]; mPtr[used] = stepped(used, delta);
        expAddr = seen(used, mMode[used]); mPtr[used] = keep;
      end
    end else begin
      expAddr = (mSel >= 2) ? frameAddr(mPtr[3]) : seen(mSel, mMode[mSel]);
    end
    case (rs)
      0: expRd = mSel + 4 * (mMode[0] + 2 * mMode[1] + 4 * mMode[2]);
      1: expRd = seen(0, mMode[0]);
      2: expRd = seen(1, mMode[1]);
      3: expRd = seen(2, mMode[2]);
      4: expRd = seen(3, mMode[2]);
      default: expRd = 0;
    endcase
    #1;
    check(int'(memAddr), expAddr, {req, " addr"});
    check(int'(regRdData), expRd, {req, " rd"});
    // advance model: step first, then register write overrides
    if (delta != 0) mPtr[used] = stepped(used, delta);
    if (we) begin
      if (ws == 0) begin
        mSel = wd % 4; mMode[0] = (wd / 4) % 2; mMode[1] = (wd / 8) % 2; mMode[2] = (wd / 16) % 2;
      end else if (ws >= 1 && ws <= 4) begin
        mPtr[ws-1] = placed(keepOld(ws-1, delta, used), ws-1, modeOf(ws-1), wd);
        mSel = (ws <= 2) ? ws - 1 : 2;
      end else if (ae && aw) mSel = (ap >= 2) ? 2 : ap;
    end else if (ae && aw) mSel = (ap >= 2) ? 2 : ap;
    @(negedge clk);
  endtask

  // value of a pointer before any step of this cycle
  function automatic int keepOld(int idx, int delta, int used);
    if (delta != 0 && used == idx) begin
      int span = hiBit(idx);
      int v = seen(idx, modeOf(idx));
      v = (v - delta + span) % span;
      return placed(mPtr[idx], idx, modeOf(idx), v);
    end
    return mPtr[idx];
  endfunction

  task automatic expectRd(input int rs, input int exp, input string req);
    regWrEn = 0; accEn = 0; regRdSel = 3'(rs);
    #1;
    check(int'(regRdData), exp, req);
  endtask

  initial begin
    foreach (mPtr[i]) mPtr[i] = 0;
    foreach (mMode[i]) mMode[i] = 0;
    mSel = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 5; r++) cyc(0, 0, 0, r, 0, 0, 0, 0, "R1");
    expectRd(0, 0, "R1 ctrl");
    // R3 mode switch keeps stored bits
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 1, 16'h2345, 1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 4, 1, 0, 0, 0, 0, "R8");
    cyc(1, 1, 16'h2345, 1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 1, 0, 0, 0, 0, "R3");
    expectRd(1, 16'h468B, "R3");
    // R4 byte-mode wrap keeps bit 16
    cyc(1, 0, 4, 1, 0, 0, 0, 0, "R8");
    cyc(1, 1, 16'h8000, 1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 1, 0, 0, 0, 0, "R8");
    cyc(1, 1, 16'hFFFF, 1, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 1, 0, 3, 1, "R4");
    expectRd(1, 16'h0000, "R4");
    cyc(1, 0, 4, 1, 0, 0, 0, 0, "R4");
    expectRd(1, 16'h8000, "R4");
    // R5 read post-step ignores accPtr, R6 write pre-step
    cyc(1, 2, 16'h0100, 2, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 2, 1, 0, 0, 2, "R5");
    expectRd(2, 16'h00FF, "R5");
    cyc(0, 0, 0, 0, 1, 1, 0, 1, "R6");
    expectRd(0, 4, "R9");
    // R7 frame pointer
    cyc(1, 3, 16'hFFF0, 3, 0, 0, 0, 0, "R7");
    cyc(1, 4, 16'h0020, 4, 0, 0, 0, 0, "R7");
    expectRd(0, 4 + 2, "R9");
    #1; check(int'(memAddr), 16'h0010, "R7 frame add");
    cyc(1, 4, 0, 4, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 4, 1, 0, 0, 2, "R7");
    expectRd(4, 16'h00FF, "R7 offset wrap");
    expectRd(3, 16'hFFF0, "R7 base held");
    cyc(1, 0, 16'h0013, 4, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 4, 1, 1, 3, 1, "R6");
    // R10 conflicts
    cyc(1, 2, 16'h1234, 2, 1, 1, 1, 1, "R10");
    expectRd(2, 16'h1234, "R10");
    cyc(1, 0, 16'h0001, 0, 1, 1, 0, 1, "R10");
    expectRd(0, 1, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // random sweep
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 3) == 0, $urandom % 8, $urandom % 65536, $urandom % 8,
          ($urandom % 2) == 0, ($urandom % 2) == 0, $urandom % 4, $urandom % 4, "R11");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule